// File: doc/BRIEF.md
# SMBus Byte-Store Target

This block is an SMBus/I2C target that fronts a 128-byte array built from registers. It oversamples the SCL and SDA lines with the system clock and recognises start and stop conditions. It shifts in the 7-bit device address and the direction bit, and acknowledges only its own address by pulling SDA low through an open-drain enable.

Once addressed, the block serves five kinds of packet. A write that carries only a data address loads the internal address counter; this is the first half of a random read. A byte write stores one byte. A page write stores a run of bytes. A current-address read returns bytes starting at the counter. A sequential read keeps returning bytes for as long as the host acknowledges. The counter walks the whole array on reads. On writes it stays inside the current eight-byte page.

An active-high protect input blocks stores without changing how the bus sees the block. Every byte is still acknowledged, and the counter moves as it would for an unprotected write. Clock stretching, packet error codes, bus timeouts and real programming delays are not modelled.

Top module: `smbee_target`

## Requirements
- R1: The block acknowledges only when the seven address bits received after a start (sent MSB first, followed by the direction bit, 1 = read) equal the DEV_ADDR parameter. Otherwise it keeps SDA released and stores nothing until the next start.
- R2: A byte write (device address with direction 0, data address, data byte, stop) stores the data byte at the data address, and every byte of it is acknowledged.
- R3: During a page write the counter increments only its low three bits, so it wraps inside the current eight-byte page. A ninth and tenth byte overwrite the first two bytes of the page, and the counter ends at the address after the last byte stored.
- R4: A current-address read returns the byte at the counter, which always holds one past the last byte read or written.
- R5: A random read, which is a write packet carrying only the data address, then a repeated start and a read packet, returns the byte at that address.
- R6: A sequential read keeps returning successive bytes while the host acknowledges, and wraps from address 127 to address 0.
- R7: The most significant bit of the received data address is ignored. Address 0x85 selects location 0x05.
- R8: While the protect input is high, write packets are fully acknowledged and the counter advances, but no array location changes.
- R9: The SDA enable changes only while SCL is low.
- R10: After the host NACKs a read byte, the block releases SDA. A stop returns it to idle, ready for the next packet.
- R11: After reset, SDA is released, every location reads 0 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| wp_i | input | 1 | Write protect, high blocks stores |
| sda_oe_o | output | 1 | Open-drain enable, high pulls SDA low |

## Verification
Assertions check on every cycle that the SDA enable moves only while the synchronised clock is low. They also check that SDA stays released while idle or while ignoring a foreign packet, that a write-side counter step never leaves its page, that a read step from the top address lands on zero, and that the array holds still while protected. What no single-cycle property can show is the end-to-end data behaviour: bytes landing at the right locations through byte and page writes, page overwrite, read wrap, the ignored address MSB, and the counter position after protected writes. The bench's bus scenarios demonstrate these by reading the array back over the bus.

// File: rtl/smbee_pkg.sv
package smbee_pkg;

    localparam int DATA_W     = 8;
    localparam int DEF_ADDR_W = 7;
    localparam int DEF_PAGE_W = 3;

    // Bus events derived from the oversampled lines
    typedef struct packed {
        logic scl;     // synchronised clock level
        logic sda;     // synchronised data level
        logic rise;    // clock rose this cycle
        logic fall;    // clock fell this cycle
        logic start;   // data fell while clock high
        logic stop;    // data rose while clock high
    } smb_evt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_HACK,
        ST_SKIP
    } link_st_t;

    typedef enum logic [1:0] {
        K_DEV,
        K_ADDR,
        K_DATA
    } rx_kind_t;

endpackage

// File: rtl/smbee_line_sync.sv
module smbee_line_sync
    import smbee_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output smb_evt_t evt
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_now;
    logic                   sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[SYNC_STAGES-1];
            sda_prev <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_now = scl_pipe[SYNC_STAGES-1];
    assign sda_now = sda_pipe[SYNC_STAGES-1];

    always_comb begin
        evt.scl   = scl_now;
        evt.sda   = sda_now;
        evt.rise  = scl_now & ~scl_prev;
        evt.fall  = ~scl_now & scl_prev;
        evt.start = scl_now & scl_prev & sda_prev & ~sda_now;
        evt.stop  = scl_now & scl_prev & ~sda_prev & sda_now;
    end

endmodule

// File: rtl/smbee_addr_ctr.sv
module smbee_addr_ctr #(
    parameter int AW = 7,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          inc_wr,
    input  logic          inc_rd,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] ctr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr <= '0;
        end else if (ld) begin
            ctr <= ld_val;
        end else if (inc_wr) begin
            ctr <= {ctr[AW-1:PW], ctr[PW-1:0] + {{(PW-1){1'b0}}, 1'b1}};
        end else if (inc_rd) begin
            ctr <= ctr + {{(AW-1){1'b0}}, 1'b1};
        end
    end

    assign addr = ctr;

    AST_WR_STAYS_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        $past(inc_wr && !ld) |-> (ctr[AW-1:PW] == $past(ctr[AW-1:PW])))
        else $error("write step left its page"); // R3

    AST_RD_WRAPS_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(inc_rd && !ld && !inc_wr) && $past(&ctr)) |-> (ctr == '0))
        else $error("read step from top did not wrap"); // R6

endmodule

// File: rtl/smbee_store.sv
module smbee_store
    import smbee_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              lock,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0][DATA_W-1:0] mem;

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (we && !lock && (addr == AW'(g))) begin
                mem[g] <= wdata;
            end
        end
    end

    assign rdata = mem[addr];

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(mem))
        else $error("array changed while protected"); // R8

endmodule

// File: rtl/smbee_target.sv
module smbee_target
    import smbee_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         ADDR_W   = DEF_ADDR_W,
    parameter int         PAGE_W   = DEF_PAGE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);

    smb_evt_t          ev;
    link_st_t          st;
    rx_kind_t          kind;
    logic [2:0]        bitcnt;
    logic [6:0]        sh;
    logic [6:0]        tx;
    logic              phase;
    logic              rd_mode;
    logic              hack;
    logic              oe;
    logic [7:0]        rx_byte;
    logic              quiet;
    logic              byte_end;
    logic              ld;
    logic              wr_req;
    logic              inc_rd;
    logic [ADDR_W-1:0] ctr;
    logic [7:0]        rd_data;

    smbee_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (ev)
    );

    // Pulses toward counter and store
    always_comb begin
        rx_byte  = {sh, ev.sda};
        quiet    = ~ev.start & ~ev.stop;
        byte_end = quiet && (st == ST_RX) && ev.rise && (bitcnt == 3'd7);
        ld       = byte_end && (kind == K_ADDR);
        wr_req   = byte_end && (kind == K_DATA);
        inc_rd   = quiet && (st == ST_TX) && ev.rise && (bitcnt == 3'd7);
    end

    smbee_addr_ctr #(.AW(ADDR_W), .PW(PAGE_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .ld     (ld),
        .ld_val (rx_byte[ADDR_W-1:0]),
        .inc_wr (wr_req),
        .inc_rd (inc_rd),
        .addr   (ctr)
    );

    smbee_store #(.AW(ADDR_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_req),
        .lock  (wp_i),
        .addr  (ctr),
        .wdata (rx_byte),
        .rdata (rd_data)
    );

    // Link-level sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            kind    <= K_DEV;
            bitcnt  <= '0;
            sh      <= '0;
            tx      <= '0;
            phase   <= 1'b0;
            rd_mode <= 1'b0;
            hack    <= 1'b0;
            oe      <= 1'b0;
        end else if (ev.start) begin
            st     <= ST_RX;
            kind   <= K_DEV;
            bitcnt <= '0;
            phase  <= 1'b0;
            oe     <= 1'b0;
        end else if (ev.stop) begin
            st    <= ST_IDLE;
            phase <= 1'b0;
            oe    <= 1'b0;
        end else begin
            unique case (st)
                ST_RX: begin
                    if (ev.rise) begin
                        sh     <= rx_byte[6:0];
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            if (kind == K_DEV) begin
                                if (rx_byte[7:1] == DEV_ADDR) begin
                                    st      <= ST_ACK;
                                    rd_mode <= rx_byte[0];
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end else begin
                                st <= ST_ACK;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        if (!phase) begin
                            oe    <= 1'b1;
                            phase <= 1'b1;
                        end else begin
                            phase  <= 1'b0;
                            bitcnt <= '0;
                            if (kind == K_DEV && rd_mode) begin
                                st <= ST_TX;
                                tx <= rd_data[6:0];
                                oe <= ~rd_data[7];
                            end else begin
                                st   <= ST_RX;
                                oe   <= 1'b0;
                                kind <= (kind == K_DEV) ? K_ADDR : K_DATA;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (ev.rise) begin
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            st <= ST_HACK;
                        end
                    end else if (ev.fall) begin
                        tx <= {tx[5:0], 1'b0};
                        oe <= ~tx[6];
                    end
                end
                ST_HACK: begin
                    if (ev.rise) begin
                        hack  <= ~ev.sda;
                        phase <= 1'b1;
                    end else if (ev.fall) begin
                        if (!phase) begin
                            oe <= 1'b0;
                        end else begin
                            phase <= 1'b0;
                            if (hack) begin
                                st     <= ST_TX;
                                bitcnt <= '0;
                                tx     <= rd_data[6:0];
                                oe     <= ~rd_data[7];
                            end else begin
                                st <= ST_SKIP;
                                oe <= 1'b0;
                            end
                        end
                    end
                end
                default: begin
                    oe <= 1'b0;
                end
            endcase
        end
    end

    assign sda_oe_o = oe;

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !$past(ev.scl))
        else $error("SDA enable moved with clock high"); // R9

    AST_FOREIGN_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP) |-> !sda_oe_o)
        else $error("SDA held while ignoring"); // R1

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe_o)
        else $error("SDA held while idle"); // R10

endmodule

// File: tb/smbee_target_tb.sv
module smbee_target_tb;

    localparam int Q = 10;
    localparam logic [7:0] DEVW = 8'hA0;
    localparam logic [7:0] DEVR = 8'hA1;
    localparam logic [7:0] FOREIGN = 8'hB0;

    // {write address, read-back address, data}
    localparam logic [23:0] VEC [8] = '{
        {8'h01, 8'h01, 8'h11},
        {8'h85, 8'h05, 8'hA7},
        {8'h0A, 8'h0A, 8'h5E},
        {8'h33, 8'h33, 8'hC9},
        {8'hF3, 8'h73, 8'h0F},
        {8'h48, 8'h48, 8'hFF},
        {8'h60, 8'h60, 8'h81},
        {8'h2F, 8'h2F, 8'h6D}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int n_chk = 0;
    int n_bad = 0;
    int viol  = 0;
    bit done  = 1'b0;
    logic prev_oe = 1'b0;
    bit acks_ok;
    bit any_ack;
    logic [7:0] rbuf [16];

    always #5 clk = ~clk;

    assign sda_line = sda_h & ~sda_oe;

    smbee_target u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_h),
        .sda_i    (sda_line),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    // R9 monitor: enable must not move while the bus clock is high
    always @(posedge clk) begin
        if (!rst && (sda_oe != prev_oe) && scl_h) viol <= viol + 1;
        prev_oe <= sda_oe;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; hq();
        scl_h = 1'b1; hq();
        sda_h = 1'b0; hq();
        scl_h = 1'b0; hq();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; hq();
        scl_h = 1'b1; hq();
        sda_h = 1'b1; hq();
    endtask

    task automatic send_byte(input logic [7:0] b);
        bit a;
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; hq();
            scl_h = 1'b1; hq(); hq();
            scl_h = 1'b0; hq();
        end
        sda_h = 1'b1; hq();
        scl_h = 1'b1; hq();
        a = ~sda_line;
        hq();
        scl_h = 1'b0; hq();
        acks_ok = acks_ok & a;
        any_ack = any_ack | a;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] d);
        sda_h = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            hq();
            scl_h = 1'b1; hq();
            d = {d[6:0], sda_line};
            hq();
            scl_h = 1'b0;
        end
        hq();
        sda_h = ack ? 1'b0 : 1'b1; hq();
        scl_h = 1'b1; hq(); hq();
        scl_h = 1'b0; hq();
        sda_h = 1'b1;
    endtask

    task automatic byte_write(input logic [7:0] a, input logic [7:0] d);
        acks_ok = 1'b1;
        bus_start();
        send_byte(DEVW);
        send_byte(a);
        send_byte(d);
        bus_stop();
    endtask

    task automatic page_write(input logic [7:0] a, input int n, input logic [7:0] base);
        acks_ok = 1'b1;
        bus_start();
        send_byte(DEVW);
        send_byte(a);
        for (int i = 0; i < n; i++) send_byte(base + 8'(i));
        bus_stop();
    endtask

    // random=1: load address first; reads n bytes, NACK on last
    task automatic read_seq(input bit random, input logic [7:0] a, input int n);
        logic [7:0] d;
        acks_ok = 1'b1;
        bus_start();
        if (random) begin
            send_byte(DEVW);
            send_byte(a);
            bus_start();
        end
        send_byte(DEVR);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, d);
            rbuf[i] = d;
        end
        chk(sda_oe == 1'b0, "R10 released after NACK", 32'(sda_oe), 0);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // Reset state
        chk(sda_oe == 1'b0, "R11 SDA released", 32'(sda_oe), 0);
        read_seq(1'b0, 8'h00, 2);
        chk(rbuf[0] == 8'h00 && rbuf[1] == 8'h00, "R11 array zero from counter 0",
            {rbuf[0], rbuf[1]}, 0);

        // Table of byte writes read back by random reads
        for (int v = 0; v < 8; v++) begin
            byte_write(VEC[v][23:16], VEC[v][7:0]);
            chk(acks_ok, "R2 byte write acknowledged", 32'(acks_ok), 1);
            read_seq(1'b1, VEC[v][15:8], 1);
            chk(rbuf[0] == VEC[v][7:0],
                (VEC[v][23:16] != VEC[v][15:8]) ? "R7 MSB ignored" : "R2 R5 random read data",
                rbuf[0], VEC[v][7:0]);
        end

        // Foreign device address
        any_ack = 1'b0;
        bus_start();
        send_byte(FOREIGN);
        send_byte(8'h0A);
        send_byte(8'h99);
        bus_stop();
        chk(any_ack == 1'b0, "R1 foreign address not acknowledged", 32'(any_ack), 0);
        read_seq(1'b1, 8'h0A, 1);
        chk(rbuf[0] == 8'h5E, "R1 foreign write stored nothing", rbuf[0], 8'h5E);

        // Page write of 10 bytes wraps inside page 0x10
        page_write(8'h10, 10, 8'h40);
        chk(acks_ok, "R3 every page byte acknowledged", 32'(acks_ok), 1);
        read_seq(1'b0, 8'h00, 1);
        chk(rbuf[0] == 8'h42, "R3 R4 counter after page wrap", rbuf[0], 8'h42);
        read_seq(1'b1, 8'h10, 8);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] e;
            e = (i < 2) ? 8'h48 + 8'(i) : 8'h40 + 8'(i);
            chk(rbuf[i] == e, "R3 page overwrite", rbuf[i], e);
        end

        // Read wrap 127 -> 0, then current read
        byte_write(8'h7F, 8'hC3);
        byte_write(8'h00, 8'h3C);
        read_seq(1'b1, 8'h7F, 2);
        chk(rbuf[0] == 8'hC3, "R6 sequential first byte", rbuf[0], 8'hC3);
        chk(rbuf[1] == 8'h3C, "R6 wrap to zero", rbuf[1], 8'h3C);
        read_seq(1'b0, 8'h00, 1);
        chk(rbuf[0] == 8'h11, "R4 current read after last+1", rbuf[0], 8'h11);

        // Write protect
        byte_write(8'h23, 8'h77);
        wp = 1'b1;
        page_write(8'h20, 3, 8'h90);
        chk(acks_ok, "R8 protected bytes acknowledged", 32'(acks_ok), 1);
        read_seq(1'b0, 8'h00, 1);
        chk(rbuf[0] == 8'h77, "R8 counter advanced under protect", rbuf[0], 8'h77);
        wp = 1'b0;
        read_seq(1'b1, 8'h20, 3);
        chk(rbuf[0] == 8'h00 && rbuf[1] == 8'h00 && rbuf[2] == 8'h00,
            "R8 protected locations unchanged", {rbuf[0], rbuf[1], rbuf[2]}, 0);

        // Block still usable after NACK + stop
        read_seq(1'b1, 8'h33, 1);
        chk(rbuf[0] == 8'hC9, "R10 new packet after stop", rbuf[0], 8'hC9);

        chk(viol == 0, "R9 enable moved only with SCL low", viol, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule